// File: doc/BRIEF.md
# I2C Bus Error Monitor and Recovery Controller

This block watches a synchronised copy of the I2C clock and data lines, follows the position of every bit inside the current frame, and raises a bus error when a START or STOP condition arrives where the frame does not allow one. The bus error sets the interrupt flag and reports status code 00h. While no event is pending the status output shows the idle code F8h. The block also takes status codes from the master and slave data paths and presents them through the same flag and status register.

The block is used by software through a small control register with four bits: start request, stop request, acknowledge enable and interrupt flag. Software recovers from a bus error by setting the stop request and clearing the interrupt flag. The controller then returns to the not-addressed slave state and clears the stop request by itself. It leaves the other control bits alone and releases both bus lines without driving a STOP condition. While an error is pending, the line drivers hold the levels they had when the error was seen.

Top module: `i2c_buserr_ctl`

## Requirements
- R1: Whenever the interrupt flag `si_q` is 0, `status_q` equals F8h. This holds after reset as well.
- R2: A pulse on `ev_valid` while `si_q` is 0 and no bus error is pending sets `si_q` and loads `ev_code` into `status_q`.
- R3: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) inside a frame, during the SCL-high of bit position 1 to 8 of a byte, sets `si_q`, sets `status_q` to 00h and clears `nas_o`. Positions 0 to 7 are the data or address bits, most significant first, and position 8 is the acknowledge bit.
- R4: A START from an idle bus, and a START or STOP during the SCL-high of position 0, are legal. Position 0 is the first high after a START or after an acknowledge. A legal condition leaves `si_q` at 0.
- R5: SDA changes while SCL is low are never taken as START or STOP.
- R6: While a bus error is pending, `scl_low_o` and `sda_low_o` keep the values they had when the error was detected, whatever `dp_scl_low`/`dp_sda_low` do. `ev_valid` cannot replace the 00h code.
- R7: When a bus error is pending, `si_q` is 0 and `sto_q` is 1, the block returns to the not-addressed slave state (`nas_o`=1) and clears `sto_q` by itself. `sta_q` and `aa_q` keep their values.
- R8: After recovery, `scl_low_o` and `sda_low_o` are 0 and no STOP is driven. They stay 0 until a START is seen on the bus; after that they follow the data path again.
- R9: Clearing `si_q` without setting `sto_q` leaves the error pending. The line outputs stay held and `nas_o` stays 0.
- R10: A control write with the interrupt-flag bit equal to 1 does not change `si_q`. Only a write of 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| dp_scl_low | input | 1 | Data path request to pull SCL low |
| dp_sda_low | input | 1 | Data path request to pull SDA low |
| ev_valid | input | 1 | Data path status event strobe |
| ev_code | input | 8 | Status code of the data path event |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sta | input | 1 | Written start-request bit |
| ctl_sto | input | 1 | Written stop-request bit |
| ctl_aa | input | 1 | Written acknowledge-enable bit |
| ctl_si | input | 1 | Written interrupt-flag bit (0 clears) |
| sta_q | output | 1 | Start-request bit |
| sto_q | output | 1 | Stop-request bit |
| aa_q | output | 1 | Acknowledge-enable bit |
| si_q | output | 1 | Interrupt flag |
| status_q | output | 8 | Status code |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| nas_o | output | 1 | Not-addressed slave state, no error pending |
| frame_o | output | 1 | A frame is open on the bus |

## Verification
The bench injects a START and a STOP at every bit position from 1 to 8, including the acknowledge. A position counter that is off by one would either miss the error at position 8 or report one on a legal STOP after the acknowledge. Repeated START and STOP at position 0, and SDA toggling while SCL is low, check that a too-eager detector raises no false error. During an error the data path requests change and an event arrives, so a design that does not freeze its drivers or lets events overwrite 00h is exposed. Recovery is checked in two steps: first the flag alone is cleared, which must keep the error, and then the stop request is set. Stuck stop requests, lost start or acknowledge bits, and outputs that are not released or are released only until the next clock are all caught.

// File: rtl/i2c_buserr_ctl.sv
module i2c_buserr_ctl #(
  parameter int          SYNC_STAGES = 2,
  parameter int          CODE_W      = 8,
  parameter int          BYTE_POS    = 9,
  parameter logic [7:0]  IDLE_CODE   = 8'hF8,
  parameter logic [7:0]  BERR_CODE   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              dp_scl_low,
  input  logic              dp_sda_low,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ctl_we,
  input  logic              ctl_sta,
  input  logic              ctl_sto,
  input  logic              ctl_aa,
  input  logic              ctl_si,
  output logic              sta_q,
  output logic              sto_q,
  output logic              aa_q,
  output logic              si_q,
  output logic [CODE_W-1:0] status_q,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              nas_o,
  output logic              frame_o
);

  localparam int PW = $clog2(BYTE_POS);
  localparam logic [PW-1:0] POS_LAST = PW'(BYTE_POS - 1);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p;
  logic [PW-1:0] cur_pos, next_pos;
  logic in_frame, err_q, rel_q, hold_scl, hold_sda;
  logic [CODE_W-1:0] code_q;

  wire scl_s     = scl_sync[SYNC_STAGES-1];
  wire sda_s     = sda_sync[SYNC_STAGES-1];
  wire start_det = scl_s && scl_p && sda_p && !sda_s;
  wire stop_det  = scl_s && scl_p && !sda_p && sda_s;
  wire scl_rise  = scl_s && !scl_p;
  wire illegal   = !err_q && in_frame && (start_det || stop_det) && (cur_pos != '0);
  wire recover   = err_q && sto_q && !si_q;
  wire ev_take   = ev_valid && !si_q && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cur_pos  <= '0;
      next_pos <= '0;
    end else if (recover) begin
      in_frame <= 1'b0;
      cur_pos  <= '0;
      next_pos <= '0;
    end else if (start_det) begin
      in_frame <= 1'b1;
      cur_pos  <= '0;
      next_pos <= '0;
    end else if (stop_det) begin
      in_frame <= 1'b0;
    end else if (scl_rise && in_frame) begin
      cur_pos  <= next_pos;
      next_pos <= (next_pos == POS_LAST) ? '0 : next_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= 1'b0;
      sto_q <= 1'b0;
      aa_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        sta_q <= ctl_sta;
        sto_q <= ctl_sto;
        aa_q  <= ctl_aa;
      end
      if (recover) sto_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q   <= 1'b0;
      code_q <= IDLE_CODE;
    end else if (illegal) begin
      si_q   <= 1'b1;
      code_q <= BERR_CODE;
    end else if (ev_take) begin
      si_q   <= 1'b1;
      code_q <= ev_code;
    end else if (ctl_we && !ctl_si) begin
      si_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      rel_q    <= 1'b0;
      hold_scl <= 1'b0;
      hold_sda <= 1'b0;
    end else begin
      if (illegal) begin
        err_q    <= 1'b1;
        hold_scl <= scl_low_o;
        hold_sda <= sda_low_o;
      end else if (recover) begin
        err_q    <= 1'b0;
      end
      if (recover)        rel_q <= 1'b1;
      else if (start_det) rel_q <= 1'b0;
    end
  end

  assign status_q  = si_q ? code_q : IDLE_CODE;
  assign scl_low_o = err_q ? hold_scl : (!rel_q && dp_scl_low);
  assign sda_low_o = err_q ? hold_sda : (!rel_q && dp_sda_low);
  assign nas_o     = !err_q;
  assign frame_o   = in_frame;

endmodule

// File: rtl/i2c_buserr_chk.sv
module i2c_buserr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err_q,
  input logic       ctl_we,
  input logic       sta_q,
  input logic       sto_q,
  input logic       aa_q,
  input logic       si_q,
  input logic [7:0] status_q,
  input logic       scl_low_o,
  input logic       sda_low_o,
  input logic       nas_o
);

  a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !si_q |-> status_q == 8'hF8);

  a_r3_error_reported: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (si_q && status_q == 8'h00));

  a_r6_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && si_q && status_q == 8'h00) |=> (!si_q || status_q == 8'h00));

  a_r6_lines_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> (!err_q || ($stable(scl_low_o) && $stable(sda_low_o))));

  a_r7_sto_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && sto_q && !si_q) |=> (!sto_q && nas_o));

  a_r7_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && sto_q && !si_q && !ctl_we) |=> ($stable(sta_q) && $stable(aa_q)));

  a_r8_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && sto_q && !si_q) |=> (!scl_low_o && !sda_low_o));

endmodule

bind i2c_buserr_ctl i2c_buserr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .err_q(err_q), .ctl_we(ctl_we),
  .sta_q(sta_q), .sto_q(sto_q), .aa_q(aa_q), .si_q(si_q),
  .status_q(status_q), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
  .nas_o(nas_o)
);

// File: tb/i2c_buserr_ctl_test.sv
module i2c_buserr_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, dps = 1'b0, dpd = 1'b0;
  logic ev_valid = 1'b0, ctl_we = 1'b0;
  logic ctl_sta = 1'b0, ctl_sto = 1'b0, ctl_aa = 1'b0, ctl_si = 1'b0;
  logic [7:0] ev_code = 8'h00;
  logic sta_q, sto_q, aa_q, si_q, scl_low_o, sda_low_o, nas_o, frame_o;
  logic [7:0] status_q;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  i2c_buserr_ctl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .dp_scl_low(dps), .dp_sda_low(dpd), .ev_valid(ev_valid), .ev_code(ev_code),
    .ctl_we(ctl_we), .ctl_sta(ctl_sta), .ctl_sto(ctl_sto), .ctl_aa(ctl_aa),
    .ctl_si(ctl_si), .sta_q(sta_q), .sto_q(sto_q), .aa_q(aa_q), .si_q(si_q),
    .status_q(status_q), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .nas_o(nas_o), .frame_o(frame_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    settle();
  endtask

  task automatic bus_start();
    lines(1, 1); lines(1, 0); lines(0, 0);
  endtask

  task automatic bus_stop();
    lines(0, 0); lines(1, 0); lines(1, 1);
  endtask

  task automatic bus_bit(input logic b);
    lines(0, b); lines(1, b); lines(0, b);
  endtask

  task automatic ctl_write(input logic s, input logic p, input logic a, input logic i);
    @(negedge clk);
    ctl_we = 1'b1; ctl_sta = s; ctl_sto = p; ctl_aa = a; ctl_si = i;
    @(negedge clk);
    ctl_we = 1'b0;
    settle();
  endtask

  task automatic pulse_event(input logic [7:0] code);
    @(negedge clk);
    ev_valid = 1'b1; ev_code = code;
    @(negedge clk);
    ev_valid = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_q, 8'hF8);
    chk("R1 reset si", si_q, 0);
    chk("R7 reset nas", nas_o, 1);
    chk("R8 reset lines", {scl_low_o, sda_low_o}, 2'b00);
  endtask

  task automatic t_event();
    pulse_event(8'h60);
    chk("R2 event flag", si_q, 1);
    chk("R2 event code", status_q, 8'h60);
    ctl_write(0, 0, 0, 1);
    chk("R10 write si=1 ignored", si_q, 1);
    chk("R10 code kept", status_q, 8'h60);
    ctl_write(0, 0, 0, 0);
    chk("R1 cleared status", status_q, 8'hF8);
  endtask

  task automatic t_legal();
    bus_start();
    chk("R4 start from idle", si_q, 0);
    chk("R4 frame open", frame_o, 1);
    for (int i = 0; i < 9; i++) bus_bit(i[0]);
    lines(0, 1); lines(1, 1); lines(1, 0); lines(0, 0);
    chk("R4 repeated start at position 0", si_q, 0);
    for (int i = 0; i < 9; i++) bus_bit(~i[0]);
    bus_stop();
    chk("R4 stop after ack", si_q, 0);
    chk("R4 frame closed", frame_o, 0);
    bus_start();
    for (int i = 0; i < 6; i++) lines(0, i[0]);
    for (int i = 0; i < 9; i++) bus_bit(1'b0);
    bus_stop();
    chk("R5 sda toggles under scl low", si_q, 0);
    chk("R5 status idle", status_q, 8'hF8);
  endtask

  task automatic t_error(input int k, input logic use_stop);
    @(negedge clk); dps = 1'b1; dpd = 1'b1;
    bus_start();
    for (int i = 0; i < k; i++) bus_bit(i[0]);
    if (use_stop) begin lines(0, 0); lines(1, 0); lines(1, 1); end
    else begin lines(0, 1); lines(1, 1); lines(1, 0); end
    chk($sformatf("R3 pos %0d stop=%0d flag", k, use_stop), si_q, 1);
    chk($sformatf("R3 pos %0d stop=%0d code", k, use_stop), status_q, 8'h00);
    chk("R3 nas cleared", nas_o, 0);
    @(negedge clk); dps = 1'b0; dpd = 1'b0;
    settle();
    chk("R6 lines held", {scl_low_o, sda_low_o}, 2'b11);
    pulse_event(8'h28);
    chk("R6 event blocked", status_q, 8'h00);
    lines(0, sda); lines(0, 1); lines(1, 1);
    ctl_write(1, 0, 1, 0);
    chk("R1 flag cleared status", status_q, 8'hF8);
    chk("R9 lines still held", {scl_low_o, sda_low_o}, 2'b11);
    chk("R9 nas still 0", nas_o, 0);
    @(negedge clk); dps = 1'b1; dpd = 1'b1;
    ctl_write(1, 1, 1, 0);
    chk("R7 sto self clear", sto_q, 0);
    chk("R7 nas set", nas_o, 1);
    chk("R7 sta aa kept", {sta_q, aa_q}, 2'b11);
    chk("R8 lines released", {scl_low_o, sda_low_o}, 2'b00);
    chk("R8 no new error", si_q, 0);
    bus_start();
    chk("R8 data path after start", {scl_low_o, sda_low_o}, 2'b11);
    bus_stop();
    @(negedge clk); dps = 1'b0; dpd = 1'b0;
    ctl_write(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_event();
    t_legal();
    for (int k = 1; k <= 8; k++) begin
      t_error(k, 1'b0);
      t_error(k, 1'b1);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule